// File: doc/BRIEF.md
# Interrupt and Breakpoint Acknowledge Sequencer

This block is the bus-master logic that runs the two special acknowledge read cycles of a 32-bit processor bus. The core raises either an interrupt acknowledge request with a priority level, or a breakpoint trap request. The sequencer drives one read cycle with its own address and attribute pattern. It waits for the slave's termination, reruns the cycle when a retry is signalled, and reports the outcome to the core as a one-clock completion pulse.

For an interrupt, the outcome is an exception vector number. It comes from one of three sources: the automatic vector for the level, a byte supplied by the slave on the low data lines, or the spurious vector when the slave reports a bus error. For a breakpoint, any non-retry termination is reported as an illegal-instruction exception.

A programmable ignore window can mask every termination input for a set number of clocks after the cycle starts. This lets slow or noisy slaves settle before their response is taken.

Top module: `ack_seq`

## Requirements
- R1: During an interrupt acknowledge cycle (`tip` high), `addr` is all ones, `ttype` is 3, `tmod` equals the accepted level, `tsize` is 2'b01 (byte) and `rd` is 1.
- R2: During a breakpoint acknowledge cycle, `addr` is all zeros, `ttype` is 3, `tmod` is 0, `tsize` is 2'b01 and `rd` is 1.
- R3: `ts` is high for exactly one clock at the first clock of each attempt, with `tip` high. `tip` stays high until a completing termination is sampled. Terminations are first looked at in the clock after `ts`.
- R4: A termination with `ta` high and `tea` low, with `avec` high, on an interrupt cycle gives vector 24 + level (25 to 31).
- R5: The same termination with `avec` low gives the vector from `data_in[7:0]`.
- R6: `tea` alone on an interrupt cycle gives the spurious vector 24.
- R7: `ta` and `tea` high together, or `tra` high while `native_mode` is 1, reruns the same cycle: `ts` is high again in the next clock.
- R8: `tra` while `native_mode` is 0 has no effect: no restart and no completion.
- R9: With `ign_en` high and `ign_count` = N, all terminations in the strobe clock and the N clocks after it are disregarded. With `ign_en` low there is no window. A completion then appears N+2 clocks after the strobe clock (2 when there is no window).
- R10: A breakpoint cycle ended by `ta` alone or `tea` alone completes with `illegal` = 1 and `vec` = 0. Interrupt completions have `illegal` = 0.
- R11: An interrupt request starts a cycle only when `at_boundary` is high or `lock_active` is low. A request at level 0 never starts a cycle.
- R12: When both requests are raised while idle, the breakpoint cycle runs first.
- R13: `done` is a one-clock pulse in the clock after the completing termination. `tip` is low in that clock, and `vec` and `illegal` are valid with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_irq | input | 1 | Interrupt acknowledge request |
| irq_level | input | 3 | Level of the interrupt to acknowledge |
| req_bkpt | input | 1 | Breakpoint acknowledge request |
| at_boundary | input | 1 | Core is at an instruction boundary |
| lock_active | input | 1 | A locked bus sequence is in progress |
| native_mode | input | 1 | `tra` is honoured as a retry when high |
| ign_en | input | 1 | Enables the termination ignore window |
| ign_count | input | IGN_W | Length of the ignore window in clocks |
| ta | input | 1 | Transfer acknowledge |
| tea | input | 1 | Transfer error acknowledge |
| tra | input | 1 | Transfer retry acknowledge |
| avec | input | 1 | Requests the automatic vector |
| data_in | input | 8 | Vector byte from the slave |
| addr | output | ADDR_W | Cycle address |
| ttype | output | 2 | Transfer type |
| tmod | output | 3 | Transfer modifier |
| tsize | output | 2 | Transfer size |
| rd | output | 1 | Read indication |
| ts | output | 1 | Transfer start strobe |
| tip | output | 1 | Transfer in progress |
| done | output | 1 | Completion pulse |
| vec | output | 8 | Resolved vector number |
| illegal | output | 1 | Breakpoint illegal-instruction indication |

## Verification
The bench builds the block with `IGN_W` = 3. This brings the widest ignore setting, 7, within reach, so the bench can measure the window's full span against the expected N+2 latency in a few dozen clocks. It also pulses `tea` through every ignored clock, so a counter that is one clock short would turn a vector result into a spurious one. The same build covers both retry causes, the masked `tra` in non-native mode and the three vector sources.

// File: rtl/ack_pkg.sv
package ack_pkg;

  typedef enum logic [1:0] {S_IDLE, S_START, S_WAIT, S_DONE} seq_state_t;
  typedef enum logic [1:0] {T_NONE, T_OK, T_ERR, T_RETRY} term_t;

  localparam logic [1:0] TT_ACK   = 2'd3;
  localparam logic [1:0] SZ_BYTE  = 2'b01;
  localparam logic [7:0] SPUR_VEC = 8'd24;

  // automatic vector: spurious base plus level
  function automatic logic [7:0] auto_vec(input logic [2:0] lvl);
    return SPUR_VEC + {5'd0, lvl};
  endfunction

  // retry outranks everything, then normal, then error
  function automatic term_t classify(input logic ta, input logic tea,
                                     input logic tra, input logic native);
    if (native && tra)   return T_RETRY;
    else if (ta && tea)  return T_RETRY;
    else if (ta)         return T_OK;
    else if (tea)        return T_ERR;
    else                 return T_NONE;
  endfunction

endpackage

// File: rtl/ack_term_decode.sv
module ack_term_decode
  import ack_pkg::*;
(
  input  logic  sample_en,
  input  logic  ta,
  input  logic  tea,
  input  logic  tra,
  input  logic  native_mode,
  output term_t term
);
  always_comb begin
    if (sample_en) term = classify(ta, tea, tra, native_mode);
    else           term = T_NONE;
  end
endmodule

// File: rtl/ack_ignore_cnt.sv
module ack_ignore_cnt #(
  parameter int IGN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             ign_en,
  input  logic [IGN_W-1:0] setting,
  output logic             expired
);
  logic [IGN_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (load)           cnt <= ign_en ? setting : '0;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R9: the window shrinks by one every clock once loaded
  p_cnt_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/ack_vec_resolve.sv
module ack_vec_resolve
  import ack_pkg::*;
(
  input  logic       is_bk,
  input  term_t      term,
  input  logic       avec,
  input  logic [2:0] lvl,
  input  logic [7:0] dbyte,
  output logic [7:0] vec,
  output logic       illegal
);
  always_comb begin
    vec     = '0;
    illegal = 1'b0;
    if (is_bk) begin
      illegal = (term == T_OK) || (term == T_ERR);
    end else if (term == T_OK) begin
      vec = avec ? auto_vec(lvl) : dbyte;
    end else if (term == T_ERR) begin
      vec = SPUR_VEC;
    end
  end
endmodule

// File: rtl/ack_seq.sv
module ack_seq
  import ack_pkg::*;
#(
  parameter int IGN_W  = 8,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_irq,
  input  logic [2:0]        irq_level,
  input  logic              req_bkpt,
  input  logic              at_boundary,
  input  logic              lock_active,
  input  logic              native_mode,
  input  logic              ign_en,
  input  logic [IGN_W-1:0]  ign_count,
  input  logic              ta,
  input  logic              tea,
  input  logic              tra,
  input  logic              avec,
  input  logic [7:0]        data_in,
  output logic [ADDR_W-1:0] addr,
  output logic [1:0]        ttype,
  output logic [2:0]        tmod,
  output logic [1:0]        tsize,
  output logic              rd,
  output logic              ts,
  output logic              tip,
  output logic              done,
  output logic [7:0]        vec,
  output logic              illegal
);
  seq_state_t st;
  logic       is_bk;
  logic [2:0] lvl_q;
  logic [7:0] vec_q;
  logic       ill_q;

  // named internal events
  logic  irq_ok, start_bk, start_irq, load_cnt, window_over, sample_en;
  logic  finish, retry;
  term_t term;
  logic [7:0] res_vec;
  logic       res_ill;

  assign irq_ok    = req_irq && (irq_level != 3'd0) && (at_boundary || !lock_active);
  assign start_bk  = (st == S_IDLE) && req_bkpt;
  assign start_irq = (st == S_IDLE) && !req_bkpt && irq_ok;
  assign load_cnt  = (st == S_START);
  assign sample_en = (st == S_WAIT) && window_over;
  assign retry     = (term == T_RETRY);
  assign finish    = (term == T_OK) || (term == T_ERR);

  ack_ignore_cnt #(.IGN_W(IGN_W)) u_ign (
    .clk(clk), .rst_n(rst_n), .load(load_cnt), .ign_en(ign_en),
    .setting(ign_count), .expired(window_over)
  );

  ack_term_decode u_term (
    .sample_en(sample_en), .ta(ta), .tea(tea), .tra(tra),
    .native_mode(native_mode), .term(term)
  );

  ack_vec_resolve u_vec (
    .is_bk(is_bk), .term(term), .avec(avec), .lvl(lvl_q), .dbyte(data_in),
    .vec(res_vec), .illegal(res_ill)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      is_bk <= 1'b0;
      lvl_q <= '0;
      vec_q <= '0;
      ill_q <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (start_bk) begin
            st <= S_START; is_bk <= 1'b1; lvl_q <= '0;
          end else if (start_irq) begin
            st <= S_START; is_bk <= 1'b0; lvl_q <= irq_level;
          end
        end
        S_START: st <= S_WAIT;
        S_WAIT: begin
          if (retry) st <= S_START;
          else if (finish) begin
            st    <= S_DONE;
            vec_q <= res_vec;
            ill_q <= res_ill;
          end
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ts      = (st == S_START);
  assign tip     = (st == S_START) || (st == S_WAIT);
  assign done    = (st == S_DONE);
  assign vec     = vec_q;
  assign illegal = ill_q;
  assign addr    = (tip && !is_bk) ? {ADDR_W{1'b1}} : '0;
  assign ttype   = tip ? TT_ACK : 2'd0;
  assign tmod    = tip ? lvl_q : 3'd0;
  assign tsize   = tip ? SZ_BYTE : 2'd0;
  assign rd      = tip;

  // R3: strobe lasts one clock and sits inside the cycle
  p_ts_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ts |=> !ts);
  p_ts_in_tip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ts |-> tip);
  // R1: interrupt cycle attributes, level never zero
  p_irq_attr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tip && !is_bk) |-> (addr == {ADDR_W{1'b1}} && tmod != 3'd0 && ttype == 2'd3));
  // R2: breakpoint cycle attributes
  p_bk_attr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tip && is_bk) |-> (addr == '0 && tmod == 3'd0 && ttype == 2'd3));
  // R7: a retry restarts the strobe next clock
  p_retry_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && retry) |=> ts);
  // R13: completion is a single pulse outside the cycle
  p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_no_tip_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!tip && $past(tip)));
endmodule

// File: tb/ack_seq_tb.sv
module ack_seq_tb;
  localparam int IGN_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_irq = 0, req_bkpt = 0, at_boundary = 1, lock_active = 0;
  logic native_mode = 0, ign_en = 0, ta = 0, tea = 0, tra = 0, avec = 0;
  logic [2:0] irq_level = 0;
  logic [IGN_W-1:0] ign_count = 0;
  logic [7:0] data_in = 0;
  logic [31:0] addr;
  logic [1:0] ttype, tsize;
  logic [2:0] tmod;
  logic rd, ts, tip, done, illegal;
  logic [7:0] vec;

  always #4 clk = ~clk;

  ack_seq #(.IGN_W(IGN_W), .ADDR_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_irq(req_irq), .irq_level(irq_level),
    .req_bkpt(req_bkpt), .at_boundary(at_boundary), .lock_active(lock_active),
    .native_mode(native_mode), .ign_en(ign_en), .ign_count(ign_count),
    .ta(ta), .tea(tea), .tra(tra), .avec(avec), .data_in(data_in),
    .addr(addr), .ttype(ttype), .tmod(tmod), .tsize(tsize), .rd(rd),
    .ts(ts), .tip(tip), .done(done), .vec(vec), .illegal(illegal)
  );

  typedef struct packed { logic ill; logic [7:0] v; } exp_t;
  exp_t sb_q[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb_q.size() == 0) chk(0, "R13 unexpected done", {23'd0, illegal, vec}, 0);
      else begin
        exp_t e;
        e = sb_q.pop_front();
        chk({illegal, vec} == {e.ill, e.v}, "R4/R5/R6/R10 result",
            {23'd0, illegal, vec}, {23'd0, e.ill, e.v});
      end
    end
  end

  task automatic noise(input int n, inout int lat);
    for (int i = 0; i < n + 1; i++) begin
      tea = 1'b1;
      @(negedge clk);
      lat++;
      chk(!done && tip, "R9 termination in window not ignored", {30'd0, done, tip}, 1);
    end
    tea = 1'b0;
  endtask

  // rcode: 0 none, 2 ta+tea, 3 tra; fcode: 0 ta, 1 tea
  task automatic do_ack(input bit bk, input bit both, input logic [2:0] lvl,
                        input int rcode, input int nret, input int fcode,
                        input bit av, input logic [7:0] db);
    int n;
    int lat;
    bit skip;
    exp_t e;
    n = ign_en ? int'(ign_count) : 0;
    skip = 0;
    if (bk) e = '{ill: 1'b1, v: 8'd0};
    else if (fcode == 1) e = '{ill: 1'b0, v: 8'd24};
    else e = '{ill: 1'b0, v: av ? (8'd24 + {5'd0, lvl}) : db};
    sb_q.push_back(e);
    avec = av; data_in = db;
    req_bkpt = bk; req_irq = !bk || both; irq_level = lvl;
    @(negedge clk);
    req_bkpt = 0; req_irq = 0;
    lat = 0;
    chk(ts && tip, "R3 strobe at start", {30'd0, ts, tip}, 3);
    if (bk) chk(addr == 32'h0 && tmod == 0 && ttype == 3 && tsize == 2'b01 && rd,
                both ? "R12 breakpoint first" : "R2 breakpoint attributes", addr, 0);
    else chk(addr == 32'hFFFF_FFFF && tmod == lvl && ttype == 3 && tsize == 2'b01 && rd,
             "R1 interrupt attributes", {addr[31:3], tmod}, {29'h1FFF_FFFF, lvl});
    for (int r = 0; r < nret; r++) begin
      noise(n, lat);
      if (rcode == 2) begin ta = 1; tea = 1; end
      else tra = 1;
      @(negedge clk);
      ta = 0; tea = 0; tra = 0;
      if (rcode == 3 && !native_mode) begin
        chk(!ts && tip && !done, "R8 tra ignored in non-native mode", {29'd0, ts, tip, done}, 2);
        skip = 1;
        lat += 1;
      end else begin
        chk(ts, "R7 retry restarts cycle", {31'd0, ts}, 1);
        lat = 0;
      end
    end
    if (!skip) noise(n, lat);
    if (fcode == 0) ta = 1; else tea = 1;
    @(negedge clk);
    lat++;
    ta = 0; tea = 0;
    chk(done && !tip, "R13 done after termination", {30'd0, done, tip}, 2);
    chk(lat == (skip ? n + 3 : n + 2), "R9 completion latency", lat, skip ? n + 3 : n + 2);
    @(negedge clk);
    chk(!done, "R13 done is one clock", {31'd0, done}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!tip && !ts && !done && addr == 0, "R3 reset idle", {29'd0, tip, ts, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    do_ack(0, 0, 3'd5, 0, 0, 0, 1, 8'h00);   // R4 level 5 -> 29
    do_ack(0, 0, 3'd3, 0, 0, 0, 0, 8'h40);   // R5 byte vector
    do_ack(0, 0, 3'd7, 0, 0, 1, 1, 8'h11);   // R6 spurious
    do_ack(0, 0, 3'd1, 2, 2, 0, 1, 8'h00);   // R7 ta+tea twice
    native_mode = 1;
    do_ack(0, 0, 3'd2, 3, 1, 0, 0, 8'h8C);   // R7 tra native
    native_mode = 0;
    do_ack(0, 0, 3'd4, 3, 1, 0, 1, 8'h00);   // R8 tra ignored
    ign_en = 1; ign_count = 3'd5;
    do_ack(0, 0, 3'd6, 0, 0, 0, 1, 8'h00);   // R9 window 5
    ign_count = 3'd7;
    do_ack(0, 0, 3'd3, 0, 0, 0, 0, 8'hA5);   // R9 widest window
    do_ack(1, 0, 3'd0, 2, 1, 0, 0, 8'h00);   // R10 bkpt retry then ta
    ign_en = 0; ign_count = 3'd6;
    do_ack(0, 0, 3'd2, 0, 0, 0, 1, 8'h00);   // R9 disabled window
    do_ack(1, 0, 3'd0, 0, 0, 1, 0, 8'h00);   // R10 bkpt tea

    // R11 gating: locked and not at a boundary
    lock_active = 1; at_boundary = 0;
    req_irq = 1; irq_level = 3'd3;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!ts && !tip, "R11 locked request must wait", {30'd0, ts, tip}, 0);
    end
    req_irq = 0;
    at_boundary = 1;
    do_ack(0, 0, 3'd3, 0, 0, 0, 1, 8'h00);   // R11 boundary reached
    lock_active = 0; at_boundary = 0;
    do_ack(0, 0, 3'd6, 0, 0, 0, 0, 8'h33);   // R11 lock released
    at_boundary = 1;

    // R11 level zero never starts
    req_irq = 1; irq_level = 3'd0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!ts && !tip, "R11 level zero ignored", {30'd0, ts, tip}, 0);
    end
    req_irq = 0;
    @(negedge clk);

    do_ack(1, 1, 3'd4, 0, 0, 0, 1, 8'h00);   // R12 both requests
    @(negedge clk);
    chk(!tip && sb_q.size() == 0, "R12 scoreboard drained", sb_q.size(), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule